// File: doc/BRIEF.md
# Keypad Hex Entry Display

This block turns a 4x4 matrix keypad into a hexadecimal entry field shown on eight common-anode seven-segment digits. It drives the keypad columns low one at a time in rotation. It reads the active-low row lines back through a two-flop synchronizer and resolves each full column sweep into one of three outcomes: no key, exactly one key, or several keys.

An accepted key shifts an eight-digit register one nibble to the left and puts the new hex digit in the rightmost position. The oldest digit falls off the left end. A key is accepted once per press. The press must read the same for a set number of consecutive sweeps, and a new press is possible only after a sweep with no key down.

The display side works from its own tick divider. It walks a single low digit enable across the eight positions and drives the matching active-low segment pattern. The register contents are also brought out as a 32-bit word.

Top module: `keypad_hex_display`

## Requirements
- R1: While reset is asserted, `digits_o` is 0x00000000, `col_o` is 4'b1110, `dig_en_o` is 8'b11111110 and `seg_o` is 8'hC0 (the pattern for 0).
- R2: Each accepted key moves `digits_o` left by four bits and loads the key's digit into bits [3:0], discarding bits [31:28]. For example, 0x486C8763 followed by key 1 becomes 0x86C87631.
- R3: `col_o` always has exactly one low bit. It changes only every SCAN_DIV clocks, stepping 1110, 1101, 1011, 0111 and then back to 1110.
- R4: A low `row_i[r]` seen while `col_o[c]` is low decodes to the digit 15 - 4c - r. So column bit 0 gives C..F for row bits 3..0, and column bit 3 gives 0..3 for row bits 3..0.
- R5: A key held down for any length of time produces exactly one shift. The same key, pressed again after a full sweep with no key down, shifts again.
- R6: A key must read the same for DEB_CYCLES consecutive full sweeps before it is accepted. A shorter press leaves `digits_o` unchanged.
- R7: If two or more keys are down in the same sweep, whether in one column or in different columns, that sweep produces no shift.
- R8: `seg_o` is active low with segment a in bit 0 and the decimal point in bit 7, which is always 1. The codes for digits 0..F are C0, F9, A4, B0, 99, 92, 82, F8, 80, 98, 88, 83, C6, A1, 86, 8E.
- R9: `dig_en_o` always has exactly one low bit, and it advances every REF_DIV clocks from bit 0 up to bit 7 and then back to bit 0. While bit i is low, `seg_o` shows `digits_o[4i+3:4i]`, so bit 0 is the rightmost digit.
- R10: `digits_o` shows the entry register at all times, and it changes only on an accepted key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_i | input | 4 | Keypad row lines, active low |
| col_o | output | 4 | Keypad column drives, one low at a time |
| seg_o | output | 8 | Segment lines, active low, bit 7 is the decimal point |
| dig_en_o | output | 8 | Digit enables, active low, bit 0 is the rightmost digit |
| digits_o | output | 32 | Entry register, eight hex digits |

## Verification
The hardest cases to reach are the ones where the keypad state is only partly seen within one sweep. Two keys in different columns may look like a single key for a sweep before both show up, and a short tap can land across the boundary between two sweeps. The bench uses a keypad model that pulls rows low from the live column drive. It mixes directed same-column and cross-column double presses and taps shorter than the debounce window with randomly chosen presses. Each press is followed by a release of several sweeps, and the register is compared with a reference shift model after every release.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_ONE  = 2'd1,
    KEY_MANY = 2'd2
  } key_cls_e;

  function automatic logic [7:0] seg_code(input logic [3:0] nib);
    logic [7:0] s;
    case (nib)
      4'h0: s = 8'hC0;
      4'h1: s = 8'hF9;
      4'h2: s = 8'hA4;
      4'h3: s = 8'hB0;
      4'h4: s = 8'h99;
      4'h5: s = 8'h92;
      4'h6: s = 8'h82;
      4'h7: s = 8'hF8;
      4'h8: s = 8'h80;
      4'h9: s = 8'h98;
      4'hA: s = 8'h88;
      4'hB: s = 8'h83;
      4'hC: s = 8'hC6;
      4'hD: s = 8'hA1;
      4'hE: s = 8'h86;
      default: s = 8'h8E;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/kpd_scan.sv
module kpd_scan
  import kpd_pkg::*;
#(
  parameter int SCAN_DIV   = 50000,
  parameter int DEB_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] row_i,
  output logic [3:0] col_o,
  output logic       key_valid_o,
  output logic [3:0] key_digit_o
);
  localparam int SW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam int DW = $clog2(DEB_CYCLES + 1);

  logic [SW-1:0] div_q;
  logic          tick;
  logic [1:0]    col_idx_q;
  logic [3:0]    row_m_q, row_s_q;
  logic [2:0]    cur_cnt;
  logic [1:0]    cur_r;
  logic [3:0]    cur_dig;
  logic [1:0]    acc_cnt_q, base_cnt, cyc_cnt;
  logic [2:0]    cnt_sum;
  logic [3:0]    acc_dig_q, cyc_dig;
  logic          res_valid;
  key_cls_e      cls, prev_cls_q;
  logic [3:0]    prev_dig_q;
  logic [DW-1:0] stab_q, stab_n;
  logic          same, armed_q, accept;
  logic          key_valid_q;
  logic [3:0]    key_digit_q;

  assign tick  = (div_q == SW'(SCAN_DIV - 1));
  assign col_o = ~(4'b0001 << col_idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      col_idx_q <= '0;
      row_m_q   <= '1;
      row_s_q   <= '1;
    end else begin
      div_q   <= tick ? '0 : div_q + 1'b1;
      row_m_q <= row_i;
      row_s_q <= row_m_q;
      if (tick) col_idx_q <= col_idx_q + 1'b1;
    end
  end

  // decode the synced rows of the column currently driven
  always_comb begin
    cur_cnt = 3'($countones(~row_s_q));
    cur_r   = '0;
    for (int i = 3; i >= 0; i--) begin
      if (!row_s_q[i]) cur_r = 2'(i);
    end
    cur_dig  = 4'd15 - {col_idx_q, 2'b00} - {2'b00, cur_r};
    base_cnt = (col_idx_q == 2'd0) ? 2'd0 : acc_cnt_q;
    cnt_sum  = {1'b0, base_cnt} + cur_cnt;
    cyc_cnt  = (cnt_sum >= 3'd2) ? 2'd2 : cnt_sum[1:0];
    if (cur_cnt != 3'd0)        cyc_dig = cur_dig;
    else if (col_idx_q == 2'd0) cyc_dig = 4'd0;
    else                        cyc_dig = acc_dig_q;
  end

  assign res_valid = tick && (col_idx_q == 2'd3);

  always_comb begin
    case (cyc_cnt)
      2'd0:    cls = KEY_NONE;
      2'd1:    cls = KEY_ONE;
      default: cls = KEY_MANY;
    endcase
    same = (cls == prev_cls_q) && ((cls != KEY_ONE) || (cyc_dig == prev_dig_q));
    if (!same)                          stab_n = DW'(1);
    else if (stab_q == DW'(DEB_CYCLES)) stab_n = stab_q;
    else                                stab_n = stab_q + 1'b1;
    accept = res_valid && (cls == KEY_ONE) && armed_q && (stab_n >= DW'(DEB_CYCLES));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt_q   <= '0;
      acc_dig_q   <= '0;
      prev_cls_q  <= KEY_NONE;
      prev_dig_q  <= '0;
      stab_q      <= '0;
      armed_q     <= 1'b1;
      key_valid_q <= 1'b0;
      key_digit_q <= '0;
    end else begin
      key_valid_q <= accept;
      if (accept) key_digit_q <= cyc_dig;
      if (tick) begin
        acc_cnt_q <= cyc_cnt;
        acc_dig_q <= cyc_dig;
      end
      if (res_valid) begin
        prev_cls_q <= cls;
        prev_dig_q <= cyc_dig;
        stab_q     <= stab_n;
        if (accept)                armed_q <= 1'b0;
        else if (cls == KEY_NONE)  armed_q <= 1'b1;
      end
    end
  end

  assign key_valid_o = key_valid_q;
  assign key_digit_o = key_digit_q;

  assert_col_one_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~col_o) == 1);
  assert_col_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(col_o));
  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);
  assert_many_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid && cls == KEY_MANY) |=> !key_valid_o);
endmodule

// File: rtl/digit_shift_reg.sv
module digit_shift_reg #(
  parameter int N_DIGITS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic [3:0]            digit_i,
  output logic [4*N_DIGITS-1:0] q_o
);
  localparam int W = 4 * N_DIGITS;

  logic [W-1:0] q_q;

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_stage
    logic [3:0] d;
    if (g == 0) begin : g_in
      assign d = digit_i;
    end else begin : g_chain
      assign d = q_q[4*(g-1) +: 4];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_q[4*g +: 4] <= '0;
      else if (shift_i) q_q[4*g +: 4] <= d;
    end
  end

  assign q_o = q_q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(q_o));
  assert_insert_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> q_o[3:0] == $past(digit_i));
endmodule

// File: rtl/disp_mux.sv
module disp_mux
  import kpd_pkg::*;
#(
  parameter int N_DIGITS = 8,
  parameter int REF_DIV  = 6250
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [4*N_DIGITS-1:0] q_i,
  output logic [N_DIGITS-1:0]   dig_en_o,
  output logic [7:0]            seg_o
);
  localparam int RW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int IW = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1;

  logic [RW-1:0] div_q;
  logic [IW-1:0] idx_q;
  logic          tick;
  logic [3:0]    nib;

  assign tick = (div_q == RW'(REF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      idx_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) idx_q <= (idx_q == IW'(N_DIGITS - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign nib      = q_i[4*idx_q +: 4];
  assign dig_en_o = ~(N_DIGITS'(1) << idx_q);
  assign seg_o    = seg_code(nib);

  assert_dig_one_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dig_en_o) == 1);
  assert_dig_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(dig_en_o));
  assert_dp_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o[7]);
endmodule

// File: rtl/keypad_hex_display.sv
module keypad_hex_display #(
  parameter int SCAN_DIV   = 50000,
  parameter int DEB_CYCLES = 4,
  parameter int REF_DIV    = 6250
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  row_i,
  output logic [3:0]  col_o,
  output logic [7:0]  seg_o,
  output logic [7:0]  dig_en_o,
  output logic [31:0] digits_o
);
  localparam int N_DIGITS = 8;

  logic       key_valid;
  logic [3:0] key_digit;

  kpd_scan #(
    .SCAN_DIV  (SCAN_DIV),
    .DEB_CYCLES(DEB_CYCLES)
  ) i_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_i      (row_i),
    .col_o      (col_o),
    .key_valid_o(key_valid),
    .key_digit_o(key_digit)
  );

  digit_shift_reg #(
    .N_DIGITS(N_DIGITS)
  ) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(key_valid),
    .digit_i(key_digit),
    .q_o    (digits_o)
  );

  disp_mux #(
    .N_DIGITS(N_DIGITS),
    .REF_DIV (REF_DIV)
  ) i_disp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .q_i     (digits_o),
    .dig_en_o(dig_en_o),
    .seg_o   (seg_o)
  );
endmodule

// File: tb/test_keypad_hex_display.sv
module test_keypad_hex_display;
  localparam int CLK_PERIOD = 10;
  localparam int SCAN_DIV   = 8;
  localparam int DEB_CYCLES = 3;
  localparam int REF_DIV    = 5;
  localparam int SWEEP      = 4 * SCAN_DIV;
  localparam int LIMIT      = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  row;
  logic [3:0]  col;
  logic [7:0]  seg;
  logic [7:0]  dig_en;
  logic [31:0] digits;
  logic [15:0] keys = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] model = '0;
  logic [3:0] prev_col = 4'b1110;
  int prev_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_hex_display #(
    .SCAN_DIV  (SCAN_DIV),
    .DEB_CYCLES(DEB_CYCLES),
    .REF_DIV   (REF_DIV)
  ) i_keypad_hex_display (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .row_i   (row),
    .col_o   (col),
    .seg_o   (seg),
    .dig_en_o(dig_en),
    .digits_o(digits)
  );

  // keypad model: digit 15-4c-r sits at column c, row r
  always_comb begin
    row = 4'b1111;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        if (!col[c] && keys[15 - 4*c - r]) row[r] = 1'b0;
  end

  function automatic logic [7:0] ref_seg(input logic [3:0] d);
    case (d)
      4'h0: return 8'hC0; 4'h1: return 8'hF9; 4'h2: return 8'hA4; 4'h3: return 8'hB0;
      4'h4: return 8'h99; 4'h5: return 8'h92; 4'h6: return 8'h82; 4'h7: return 8'hF8;
      4'h8: return 8'h80; 4'h9: return 8'h98; 4'hA: return 8'h88; 4'hB: return 8'h83;
      4'hC: return 8'hC6; 4'hD: return 8'hA1; 4'hE: return 8'h86; default: return 8'h8E;
    endcase
  endfunction

  function automatic logic [31:0] shifted(input logic [31:0] m, input logic [3:0] d);
    return {m[27:0], d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_sweeps(input int n);
    repeat (n * SWEEP) @(negedge clk);
  endtask

  task automatic press(input logic [15:0] mask, input int hold, input bit take, input logic [3:0] d,
                       input string tag);
    keys = mask;
    wait_sweeps(hold);
    keys = '0;
    wait_sweeps(3);
    if (take) model = shifted(model, d);
    chk(digits === model, tag, digits, model);
  endtask

  // R3 column rotation, R8/R9 segment and enable monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int idx, lows;
      if (col !== prev_col)
        chk(col === {prev_col[2:0], prev_col[3]}, "R3 col step", {28'd0, col},
            {28'd0, prev_col[2:0], prev_col[3]});
      prev_col = col;
      lows = 0; idx = 0;
      for (int i = 0; i < 8; i++) if (!dig_en[i]) begin lows++; idx = i; end
      chk(lows == 1, "R9 one enable", {24'd0, dig_en}, 32'd0);
      if (idx != prev_idx)
        chk(idx == (prev_idx + 1) % 8, "R9 enable order", idx, (prev_idx + 1) % 8);
      prev_idx = idx;
      chk(seg === ref_seg(digits[4*idx +: 4]), "R8 R9 segment", {24'd0, seg},
          {24'd0, ref_seg(digits[4*idx +: 4])});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] seq [9];
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(digits === 32'h0, "R1 digits", digits, 32'h0);
    chk(col === 4'b1110, "R1 col", {28'd0, col}, 32'hE);
    chk(dig_en === 8'hFE, "R1 enable", {24'd0, dig_en}, 32'hFE);
    chk(seg === 8'hC0, "R1 seg", {24'd0, seg}, 32'hC0);
    rst_n = 1'b1;

    // R4 every key in turn, R2 and R10 on each step
    for (int d = 0; d < 16; d++)
      press(16'(1) << d, 6, 1'b1, 4'(d), "R4 R2 decode/shift");

    // R2 full register drops oldest digit
    seq = '{4'h4, 4'h8, 4'h6, 4'hC, 4'h8, 4'h7, 4'h6, 4'h3, 4'h1};
    for (int i = 0; i < 8; i++) press(16'(1) << seq[i], 6, 1'b1, seq[i], "R2 fill");
    chk(digits === 32'h486C8763, "R2 full", digits, 32'h486C8763);
    press(16'(1) << seq[8], 6, 1'b1, seq[8], "R2 overflow");
    chk(digits === 32'h86C87631, "R2 drop oldest", digits, 32'h86C87631);

    // R5 long hold shifts once; repeat press shifts again
    press(16'h0020, 20, 1'b1, 4'h5, "R5 long hold");
    press(16'h0020, 6, 1'b1, 4'h5, "R5 repress");

    // R6 tap shorter than debounce window
    keys = 16'h0200;
    repeat (SWEEP + SCAN_DIV) @(negedge clk);
    keys = '0;
    wait_sweeps(3);
    chk(digits === model, "R6 short tap", digits, model);

    // R7 two keys in one column, then in different columns
    press(16'h0003, 6, 1'b0, 4'h0, "R7 same column");
    press(16'h8001, 6, 1'b0, 4'h0, "R7 cross column");
    press(16'h0100, 6, 1'b1, 4'h8, "R7 recovery");

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      int kind;
      logic [3:0] a, b;
      kind = $urandom_range(0, 5);
      a = 4'($urandom_range(0, 15));
      b = 4'($urandom_range(0, 15));
      if (b == a) b = a + 4'd1;
      if (kind == 0) begin
        keys = 16'(1) << a;
        repeat (SWEEP) @(negedge clk);
        keys = '0;
        wait_sweeps(3);
        chk(digits === model, "R6 random tap", digits, model);
      end else if (kind == 1) begin
        press((16'(1) << a) | (16'(1) << b), 6, 1'b0, 4'h0, "R7 random multi");
      end else begin
        press(16'(1) << a, 5 + int'($urandom_range(0, 3)), 1'b1, a, "R2 R5 random press");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule